// File: doc/BRIEF.md
# Protocol Discovery Responder

This block serves the discovery request of a data-object mailbox. The mailbox logic feeds it the dwords of a request, one per cycle, then raises a one-cycle `go` strobe. A request needs at least three dwords: a two-dword header and a third dword whose low byte is the index being queried. A shorter request is dropped, and a one-cycle `discard` pulse reports the drop. A request of full length is answered with a three-dword response streamed out on consecutive cycles, and `done` marks the last dword.

The response names the protocol found at the queried index and the index to ask for next. A software agent can walk the whole list by starting at 0 and following the next index until it comes back as 0. The supported protocols are set by parameter as a packed table of 24-bit entries. Each entry has a 16-bit vendor ID and an 8-bit object type. Discovery itself always occupies index 0, so the total count is the table size plus one.

Top module: `proto_disc_responder`

## Requirements
- R1: During and directly after reset, `rspValid`, `done` and `discard` are 0.
- R2: When `go` arrives after fewer than three request dwords have been accepted since the last response or discard, `discard` is 1 for exactly the next cycle and no response dword is produced. A dword offered in the same cycle as `go` is not counted.
- R3: When `go` arrives after three or more dwords, `rspValid` is 1 for exactly the three cycles after that edge, and `done` is 1 only in the third of them.
- R4: Response dword 0 is 0x00000001 (vendor ID 0x0001 in bits 15:0, object type 0x00 in bits 23:16). Response dword 1 is 0x00000003 (a length of 3 dwords in bits 17:0).
- R5: For index 0, response dword 2 carries vendor ID 0x0001 and object type 0x00.
- R6: For an index i with 1 <= i < total count, dword 2 carries table entry i-1. Entry p occupies parameter bits [24p+23:24p], with the vendor ID in the low 16 bits and the type in the high 8 bits.
- R7: For an index at or beyond the total count, dword 2 carries vendor ID 0xFFFF and object type 0xFF.
- R8: Dword 2 packs the vendor ID in bits 15:0, the type in bits 23:16 and the next index in bits 31:24. The next index is 0 when index+1 equals the total count, and otherwise (index+1) mod 256.
- R9: The index is bits 7:0 of the third accepted dword. Its bits 31:8 and any dwords after the third do not affect the response.
- R10: While a response is being streamed, `reqValid` and `go` are ignored. After `done` or `discard`, dword counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | A request dword is offered this cycle |
| reqData | input | 32 | Request dword |
| go | input | 1 | Strobe: evaluate the dwords collected so far |
| rspValid | output | 1 | A response dword is on `rspData` |
| rspData | output | 32 | Response dword |
| done | output | 1 | Last response dword this cycle |
| discard | output | 1 | The request was too short and was dropped |

## Verification
A stale dword counter shows up right away, on the first `go` after a response. It gives a spurious response where a discard is due, or the reverse, one cycle after the strobe. A wrong captured index or a wrong table lookup appears only in the third response dword, two cycles after the response starts. Walking every index, including the last valid one and values past the end, exposes off-by-one errors in both the entry selection and the wrap of the next index. Stimulus offered during a response checks that the control ignores it. If it does not, the next request is discarded or answered wrongly.

// File: rtl/disc_pkg.sv
package disc_pkg;

  localparam logic [15:0] DISC_VID  = 16'h0001;
  localparam logic [7:0]  DISC_TYPE = 8'h00;
  localparam int          RSP_LEN   = 3;
  localparam int          MIN_REQ   = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_W0   = 2'd1,
    ST_W1   = 2'd2,
    ST_W2   = 2'd3
  } discState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;
    logic       clear;
    logic [1:0] sel;
  } dpStrobes_t;

endpackage

// File: rtl/disc_ctrl.sv
module disc_ctrl
  import disc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       go,
  input  logic       enough,
  output dpStrobes_t strb,
  output logic       rspValid,
  output logic       done,
  output logic       discard
);

  discState_t state, stateNext;
  logic       discardQ;
  logic       idle;

  assign idle = (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (go && enough) stateNext = ST_W0;
      ST_W0:   stateNext = ST_W1;
      ST_W1:   stateNext = ST_W2;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      discardQ <= 1'b0;
    end else begin
      state    <= stateNext;
      discardQ <= idle && go && !enough;
    end
  end

  always_comb begin
    strb.clear   = idle && go;
    strb.capture = idle && reqValid && !go;
    case (state)
      ST_W1:   strb.sel = 2'd1;
      ST_W2:   strb.sel = 2'd2;
      default: strb.sel = 2'd0;
    endcase
  end

  assign rspValid = !idle;
  assign done     = (state == ST_W2);
  assign discard  = discardQ;

endmodule

// File: rtl/disc_datapath.sv
module disc_datapath
  import disc_pkg::*;
#(
  parameter int                     NUM_PROT   = 3,
  parameter logic [NUM_PROT*24-1:0] PROT_TABLE = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobes_t  strb,
  input  logic [31:0] reqData,
  output logic        enough,
  output logic [31:0] rspData
);

  localparam int TOTAL = NUM_PROT + 1;

  logic [1:0]  wordCnt;
  logic [7:0]  index;
  logic [15:0] vid;
  logic [7:0]  objType;
  logic [7:0]  nextIdx;
  logic [8:0]  idxPlus;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt <= '0;
      index   <= '0;
    end else if (strb.clear) begin
      wordCnt <= '0;
    end else if (strb.capture) begin
      if (wordCnt == 2'd2) index <= reqData[7:0];
      if (wordCnt != 2'd3) wordCnt <= wordCnt + 2'd1;
    end
  end

  assign enough = (32'(wordCnt) >= MIN_REQ);

  always_comb begin
    vid     = 16'hFFFF;
    objType = 8'hFF;
    if (index == 8'd0) begin
      vid     = DISC_VID;
      objType = DISC_TYPE;
    end
    for (int p = 0; p < NUM_PROT; p++) begin
      if (index == 8'(p + 1)) begin
        vid     = PROT_TABLE[p*24 +: 16];
        objType = PROT_TABLE[p*24 + 16 +: 8];
      end
    end
  end

  assign idxPlus = {1'b0, index} + 9'd1;
  assign nextIdx = (idxPlus == 9'(TOTAL)) ? 8'd0 : idxPlus[7:0];

  always_comb begin
    case (strb.sel)
      2'd0:    rspData = {8'h00, DISC_TYPE, DISC_VID};
      2'd1:    rspData = 32'(RSP_LEN);
      default: rspData = {nextIdx, objType, vid};
    endcase
  end

endmodule

// File: rtl/proto_disc_responder.sv
module proto_disc_responder
  import disc_pkg::*;
#(
  parameter int                     NUM_PROT   = 3,
  parameter logic [NUM_PROT*24-1:0] PROT_TABLE = {24'h7E_ABCD, 24'h05_1E98, 24'h02_1E98}
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqData,
  input  logic        go,
  output logic        rspValid,
  output logic [31:0] rspData,
  output logic        done,
  output logic        discard
);

  dpStrobes_t strb;
  logic       enough;

  disc_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .go       (go),
    .enough   (enough),
    .strb     (strb),
    .rspValid (rspValid),
    .done     (done),
    .discard  (discard)
  );

  disc_datapath #(
    .NUM_PROT   (NUM_PROT),
    .PROT_TABLE (PROT_TABLE)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqData (reqData),
    .enough  (enough),
    .rspData (rspData)
  );

endmodule

// File: rtl/disc_checker.sv
module disc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        go,
  input logic        rspValid,
  input logic [31:0] rspData,
  input logic        done,
  input logic        discard
);

  // R3: done only accompanies a valid response dword
  a_r3_done_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    done |-> rspValid);

  // R3: a response keeps going until done
  a_r3_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !done) |=> rspValid);

  // R3: the response stops after done
  a_r3_end_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !rspValid);

  // R2: a discard never overlaps a response and lasts one cycle
  a_r2_discard_no_rsp: assert property (@(posedge clk) disable iff (!rstN)
    discard |-> !rspValid);

  a_r2_discard_pulse: assert property (@(posedge clk) disable iff (!rstN)
    discard |=> !discard);

  // R2/R3: any outcome is preceded by a go strobe
  a_r2_outcome_after_go: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rspValid) || discard) |-> $past(go));

  // R4: the first response dword is the fixed discovery header
  a_r4_first_header: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> (rspData == 32'h0000_0001));

endmodule

bind proto_disc_responder disc_checker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .go       (go),
  .rspValid (rspValid),
  .rspData  (rspData),
  .done     (done),
  .discard  (discard)
);

// File: tb/proto_disc_responder_test.sv
module proto_disc_responder_test;

  localparam int NP = 3;
  localparam int TOTAL = NP + 1;
  localparam logic [NP*24-1:0] TBL = {24'h7E_ABCD, 24'h05_1E98, 24'h02_1E98};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqData = '0;
  logic        go = 1'b0;
  logic        rspValid, done, discard;
  logic [31:0] rspData;

  always #2.5 clk = ~clk;

  proto_disc_responder #(.NUM_PROT(NP), .PROT_TABLE(TBL)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqData(reqData), .go(go),
    .rspValid(rspValid), .rspData(rspData), .done(done), .discard(discard)
  );

  typedef struct {
    logic        v;
    logic        d;
    logic        x;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  exp_t cur;
  int   total = 0;
  int   bad = 0;
  int   cycles = 0;
  int   mCnt = 0;
  int   mIdx = 0;

  // behavioural table of the bench
  function automatic logic [31:0] word2(int idx);
    logic [15:0] v;
    logic [7:0]  t;
    int          nx;
    if (idx == 0) begin v = 16'h0001; t = 8'h00; end
    else if (idx < TOTAL) begin
      case (idx)
        1: begin v = 16'h1E98; t = 8'h02; end
        2: begin v = 16'h1E98; t = 8'h05; end
        default: begin v = 16'hABCD; t = 8'h7E; end
      endcase
    end else begin v = 16'hFFFF; t = 8'hFF; end
    nx = (idx + 1 == TOTAL) ? 0 : ((idx + 1) % 256);
    return {8'(nx), t, v};
  endfunction

  function automatic string w2tag(int idx);
    if (idx == 0) return "R5/R8";
    if (idx < TOTAL) return "R6/R8";
    return "R7/R8";
  endfunction

  // reference model: steps on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      expQ.delete();
      mCnt = 0;
    end else if (!cur.v) begin
      if (go) begin
        if (mCnt < 3) expQ.push_back('{1'b0, 1'b0, 1'b1, 32'h0, "R2"});
        else begin
          expQ.push_back('{1'b1, 1'b0, 1'b0, 32'h0000_0001, "R3/R4"});
          expQ.push_back('{1'b1, 1'b0, 1'b0, 32'h0000_0003, "R3/R4"});
          expQ.push_back('{1'b1, 1'b1, 1'b0, word2(mIdx), w2tag(mIdx)});
        end
        mCnt = 0;
      end else if (reqValid) begin
        if (mCnt == 2) mIdx = int'(reqData[7:0]);
        if (mCnt < 3) mCnt++;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    cycles++;
    if (!rstN) cur = '{1'b0, 1'b0, 1'b0, 32'h0, "R1"};
    else if (expQ.size() > 0) cur = expQ.pop_front();
    else cur = '{1'b0, 1'b0, 1'b0, 32'h0, "R3/R10"};
    total++;
    if (rspValid !== cur.v || done !== cur.d || discard !== cur.x ||
        (cur.v && rspData !== cur.data)) begin
      bad++;
      $display("FAIL %s: got v=%b d=%b x=%b data=%h exp v=%b d=%b x=%b data=%h",
               cur.tag, rspValid, done, discard, rspData, cur.v, cur.d, cur.x, cur.data);
    end
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      reqValid = 1'b0; go = 1'b0;
    end
  endtask

  task automatic putWord(logic [31:0] w);
    @(negedge clk);
    reqValid = 1'b1; reqData = w; go = 1'b0;
  endtask

  task automatic pulseGo();
    @(negedge clk);
    reqValid = 1'b0; go = 1'b1;
  endtask

  task automatic query(logic [31:0] third);
    putWord(32'h0000_0001);
    putWord(32'h0000_0003);
    putWord(third);
    pulseGo();
    idle(5);
  endtask

  initial begin
    idle(4);                       // R1 checked while in reset
    @(negedge clk); rstN = 1'b1;
    idle(3);
    // R2: zero and two dwords are discarded
    pulseGo(); idle(3);
    putWord(32'h1); putWord(32'h3); pulseGo(); idle(3);
    // R2: dword together with go is not counted
    putWord(32'h1); putWord(32'h3);
    @(negedge clk); reqValid = 1'b1; reqData = 32'h0; go = 1'b1;
    idle(3);
    // R5 R6 R7 R8 walk
    for (int i = 0; i < 7; i++) query(32'(i));
    query(32'h0000_00FF);          // R7/R8 wrap of 255
    // R9: upper bits and extra dwords ignored
    query(32'hABCD_EF02);
    putWord(32'h1); putWord(32'h3); putWord(32'h1);
    putWord(32'h2); putWord(32'h3); pulseGo(); idle(5);
    // R10: stimulus during a response is ignored
    putWord(32'h1); putWord(32'h3); putWord(32'h3);
    pulseGo();
    putWord(32'h9); pulseGo(); putWord(32'h9);
    idle(1);
    pulseGo(); idle(3);            // R10: counter restarted, so discard
    // back to back queries
    putWord(32'h1); putWord(32'h3); putWord(32'h2); pulseGo();
    putWord(32'h0); putWord(32'h0); putWord(32'h0); putWord(32'h0); pulseGo();
    idle(6);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule